// File: doc/BRIEF.md
# Masked Vector Floating-Point Greater-or-Equal Compare

This unit compares every element of a vector register against one scalar floating-point value, testing whether the element is greater than or equal to the scalar. The result is one bit per element, packed so that bit i belongs to element i. The element format is chosen per operation: half, single or double precision. The number of elements follows from the register length divided by the element width.

The unit applies vector-length and mask-register control to each element. Elements below the vector length are active when masking is off. When masking is on, they are active only where the mask register has a 1. Active elements receive their compare result. Inactive elements either keep the old destination bit or are forced to 1, depending on the mask-agnostic bit. Tail positions are always written to 1.

A NaN in either operand of an active element gives a 0 result and raises the invalid-operation flag. This holds for quiet and signaling NaNs alike. The whole operation takes one registered cycle with a valid strobe.

Top module: `vfcmp_ge_unit`

## Requirements
- R1: For an active element the result bit is 1 exactly when the element is greater than or equal to the scalar under IEEE ordering. Negative values order by reversed magnitude, infinities are ordered, and +0 equals -0.
- R2: Element i occupies `vec_data[i*W +: W]` for width W. The scalar is `scalar[W-1:0]`, and its upper bits are ignored. Result bit i of `out_mask` belongs to element i.
- R3: `ew_sel` encoding: 0 selects 16-bit, 1 selects 32-bit, 2 and 3 select 64-bit. The element count is VLEN/W.
- R4: An active element with a NaN in either operand (exponent all ones, nonzero fraction) gives result bit 0.
- R5: With `vm`=1 every element below `vl` is active. With `vm`=0, element i below `vl` is active only when `v0_mask[i]` is 1.
- R6: An inactive element below `vl` keeps `old_mask[i]` when `mask_agn`=0. It is written to 1 when `mask_agn`=1.
- R7: A bit whose index is at or above `vl`, or at or above the element count, is written to 1.
- R8: `out_invalid` is the OR of NaN conditions over active elements only. It is 0 when no element is active.
- R9: `out_valid` is high in the cycle after each `in_valid` cycle and low otherwise. `out_mask` and `out_invalid` update only then and otherwise hold.
- R10: Synchronous reset clears `out_valid`, `out_mask` and `out_invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| vec_data | input | VLEN | Vector operand elements |
| scalar | input | 64 | Scalar operand, low W bits used |
| vl | input | $clog2(VLEN/16+1) | Vector length in elements |
| ew_sel | input | 2 | Element width select |
| vm | input | 1 | 1 = unmasked, 0 = use v0_mask |
| v0_mask | input | VLEN/16 | Per-element enable mask |
| old_mask | input | VLEN/16 | Prior destination mask |
| mask_agn | input | 1 | Inactive-element agnostic policy |
| out_valid | output | 1 | Result valid |
| out_mask | output | VLEN/16 | Packed result mask |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The compare is tried in each of the three widths. The half-precision cases mix positive and negative values, signed zeros, subnormals, infinities and NaNs; these separate float ordering from integer ordering and show that ±0 compare equal. NaN cases are placed once on an active lane and once on an inactive lane. A NaN scalar is also used. Together these show the flag is taken over active elements only. Masked patterns with both policy settings, vl of zero, vl above the element count, and width code 3 separate the active, inactive and tail rules.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;
  typedef enum logic [1:0] {
    EW_HALF   = 2'd0,
    EW_SINGLE = 2'd1,
    EW_DOUBLE = 2'd2,
    EW_DBL_ALT = 2'd3
  } ew_sel_e;

  localparam int unsigned NUM_WIDTHS = 3;

  function automatic int unsigned exp_bits(input int unsigned w);
    if (w == 16) return 5;
    else if (w == 32) return 8;
    else return 11;
  endfunction
endpackage

// File: rtl/vfcmp_ge_lane.sv
module vfcmp_ge_lane #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] elem,
  input  logic [W-1:0] scl,
  output logic         ge,
  output logic         nan
);
  localparam int unsigned EW = vfcmp_pkg::exp_bits(W);
  localparam int unsigned MW = W - 1 - EW;

  logic         s_e, s_s;
  logic [W-2:0] mag_e, mag_s;
  logic         nan_e, nan_s, ordered_ge;

  assign s_e   = elem[W-1];
  assign s_s   = scl[W-1];
  assign mag_e = elem[W-2:0];
  assign mag_s = scl[W-2:0];
  assign nan_e = (&elem[W-2:MW]) && (|elem[MW-1:0]);
  assign nan_s = (&scl[W-2:MW]) && (|scl[MW-1:0]);
  assign nan   = nan_e | nan_s;

  always_comb begin
    if (mag_e == '0 && mag_s == '0) ordered_ge = 1'b1;
    else if (s_e != s_s)            ordered_ge = !s_e;
    else if (!s_e)                  ordered_ge = (mag_e >= mag_s);
    else                            ordered_ge = (mag_e <= mag_s);
  end

  assign ge = ordered_ge && !nan;
endmodule

// File: rtl/vfcmp_mask_policy.sv
module vfcmp_mask_policy #(
  parameter int unsigned NE  = 8,
  parameter int unsigned VLW = 4
) (
  input  logic [NE-1:0]  ge,
  input  logic [NE-1:0]  nan,
  input  logic [VLW-1:0] vl,
  input  logic [VLW-1:0] nelem,
  input  logic           vm,
  input  logic [NE-1:0]  v0,
  input  logic [NE-1:0]  old,
  input  logic           agn,
  output logic [NE-1:0]  mask,
  output logic           invalid,
  output logic [NE-1:0]  act_vec,
  output logic [NE-1:0]  inact_vec,
  output logic [NE-1:0]  tail_vec
);
  for (genvar i = 0; i < NE; i++) begin : g_bit
    assign tail_vec[i]  = (VLW'(i) >= vl) || (VLW'(i) >= nelem);
    assign act_vec[i]   = !tail_vec[i] && (vm || v0[i]);
    assign inact_vec[i] = !tail_vec[i] && !act_vec[i];
    assign mask[i] = tail_vec[i] ? 1'b1 :
                     act_vec[i] ? ge[i] :
                     (agn ? 1'b1 : old[i]);
  end

  assign invalid = |(nan & act_vec);
endmodule

// File: rtl/vfcmp_ge_unit.sv
module vfcmp_ge_unit #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned NE  = VLEN / 16,
  localparam int unsigned VLW = $clog2(NE + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VLEN-1:0] vec_data,
  input  logic [63:0]     scalar,
  input  logic [VLW-1:0]  vl,
  input  logic [1:0]      ew_sel,
  input  logic            vm,
  input  logic [NE-1:0]   v0_mask,
  input  logic [NE-1:0]   old_mask,
  input  logic            mask_agn,
  output logic            out_valid,
  output logic [NE-1:0]   out_mask,
  output logic            out_invalid
);
  import vfcmp_pkg::*;

  logic [NE-1:0] ge_w  [NUM_WIDTHS];
  logic [NE-1:0] nan_w [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned W = 16 << g;
    localparam int unsigned N = VLEN / W;
    logic [N-1:0] ge_l, nan_l;
    for (genvar i = 0; i < N; i++) begin : g_lane
      vfcmp_ge_lane #(.W(W)) u_lane (
        .elem (vec_data[i*W +: W]),
        .scl  (scalar[W-1:0]),
        .ge   (ge_l[i]),
        .nan  (nan_l[i])
      );
    end
    assign ge_w[g]  = NE'(ge_l);
    assign nan_w[g] = NE'(nan_l);
  end

  logic [1:0]     widx;
  logic [VLW-1:0] nelem;
  logic [NE-1:0]  ge_sel, nan_sel;

  always_comb begin
    unique case (ew_sel_e'(ew_sel))
      EW_HALF:   widx = 2'd0;
      EW_SINGLE: widx = 2'd1;
      default:   widx = 2'd2;
    endcase
    nelem   = VLW'(VLEN >> (4 + widx));
    ge_sel  = ge_w[widx];
    nan_sel = nan_w[widx];
  end

  logic [NE-1:0] mask_d, act_vec, inact_vec, tail_vec;
  logic          inv_d;

  vfcmp_mask_policy #(.NE(NE), .VLW(VLW)) u_policy (
    .ge        (ge_sel),
    .nan       (nan_sel),
    .vl        (vl),
    .nelem     (nelem),
    .vm        (vm),
    .v0        (v0_mask),
    .old       (old_mask),
    .agn       (mask_agn),
    .mask      (mask_d),
    .invalid   (inv_d),
    .act_vec   (act_vec),
    .inact_vec (inact_vec),
    .tail_vec  (tail_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_mask    <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask    <= mask_d;
        out_invalid <= inv_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_mask) && $stable(out_invalid))); // R9
  AST_TAIL_ONES: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> &(out_mask | ~$past(tail_vec))); // R7
  AST_INACTIVE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mask_agn) |=> (((out_mask ^ $past(old_mask)) & $past(inact_vec)) == '0)); // R6
  AST_INACTIVE_ONES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_agn) |=> &(out_mask | ~$past(inact_vec))); // R6
  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_mask & $past(act_vec & nan_sel)) == '0)); // R4
  AST_NO_ACTIVE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && act_vec == '0) |=> !out_invalid); // R8
endmodule

// File: tb/tb_vfcmp_ge_unit.sv
module tb_vfcmp_ge_unit;
  localparam int unsigned VLEN = 128;
  localparam int unsigned NE   = VLEN / 16;
  localparam int unsigned VLW  = $clog2(NE + 1);

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [VLEN-1:0] vec_data;
  logic [63:0]     scalar;
  logic [VLW-1:0]  vl;
  logic [1:0]      ew_sel;
  logic            vm;
  logic [NE-1:0]   v0_mask, old_mask;
  logic            mask_agn;
  logic            out_valid;
  logic [NE-1:0]   out_mask;
  logic            out_invalid;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vfcmp_ge_unit #(.VLEN(VLEN)) dut (.*);

  typedef struct packed {
    logic [1:0]      sel;
    logic [VLW-1:0]  vl;
    logic            vm;
    logic [NE-1:0]   v0;
    logic [NE-1:0]   old;
    logic            agn;
    logic [VLEN-1:0] vec;
    logic [63:0]     sc;
    logic [NE-1:0]   exp_mask;
    logic            exp_inv;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TABLE [NV] = '{
    // R1 R2 R4: half, mixed values, NaN active, garbage upper scalar bits
    '{2'd0, 4'd8, 1'b1, 8'h00, 8'h00, 1'b0,
      128'h7E00_3BFF_FC00_7C00_0000_BC00_4000_3C00, 64'hDEAD_BEEF_1234_3C00, 8'h13, 1'b1},
    // R1: negative scalar ordering
    '{2'd0, 4'd8, 1'b1, 8'h00, 8'h00, 1'b0,
      128'hC000_3C00_FC00_BB00_BE00_8000_BC00_C000, 64'h0000_0000_0000_BC00, 8'h56, 1'b0},
    // R1 R7: signed zeros and subnormals, vl=4
    '{2'd0, 4'd4, 1'b1, 8'h00, 8'h00, 1'b0,
      128'h0000_0000_0000_0000_0001_8001_8000_0000, 64'h0000_0000_0000_8000, 8'hFB, 1'b0},
    // R5 R6 R8: single, masked, NaN on inactive lane keeps old
    '{2'd1, 4'd4, 1'b0, 8'h0B, 8'h04, 1'b0,
      128'h3F800000_7FC00000_BF800000_40000000, 64'h0000_0000_3F80_0000, 8'hFD, 1'b0},
    // R4 R8: double, NaN scalar
    '{2'd2, 4'd2, 1'b1, 8'h00, 8'h00, 1'b0,
      128'h4000000000000000_3FF0000000000000, 64'h7FF8000000000000, 8'hFC, 1'b1},
    // R7 R8: double, signaling NaN in tail, vl=1
    '{2'd2, 4'd1, 1'b1, 8'h00, 8'h00, 1'b0,
      128'h7FF0000000000001_BFF0000000000000, 64'h3FF0000000000000, 8'hFE, 1'b0},
    // R6 R8: all inactive, agnostic
    '{2'd1, 4'd3, 1'b0, 8'h00, 8'h00, 1'b1,
      128'h3F800000_3F800000_3F800000_7FC00000, 64'h0000_0000_3F80_0000, 8'hFF, 1'b0},
    // R5 R6: alternating v0, undisturbed
    '{2'd0, 4'd8, 1'b0, 8'hAA, 8'h50, 1'b0,
      {8{16'h3C00}}, 64'h0, 8'hFA, 1'b0},
    // R3: code 3 acts as double
    '{2'd3, 4'd2, 1'b1, 8'h00, 8'h00, 1'b0,
      128'hBFF0000000000000_4000000000000000, 64'h3FF0000000000000, 8'hFD, 1'b0},
    // R7 R8: vl=0, NaNs everywhere
    '{2'd0, 4'd0, 1'b1, 8'h00, 8'h00, 1'b0,
      {8{16'h7E00}}, 64'h0000_0000_0000_3C00, 8'hFF, 1'b0},
    // R3 R7: vl above element count
    '{2'd1, 4'd8, 1'b1, 8'h00, 8'h00, 1'b0,
      {4{32'h3F800000}}, 64'h0000_0000_4000_0000, 8'hF0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t t);
    ew_sel = t.sel; vl = t.vl; vm = t.vm; v0_mask = t.v0;
    old_mask = t.old; mask_agn = t.agn; vec_data = t.vec; scalar = t.sc;
    in_valid = 1'b1;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; vec_data = '0; scalar = '0; vl = '0;
    ew_sel = '0; vm = 1'b1; v0_mask = '0; old_mask = '0; mask_agn = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 valid", 32'(out_valid), 32'd0);
    check("R10 mask", 32'(out_mask), 32'd0);
    check("R10 invalid", 32'(out_invalid), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      apply(TABLE[k]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 valid entry %0d", k), 32'(out_valid), 32'd1);
      check($sformatf("R1 R5 R6 R7 mask entry %0d", k), 32'(out_mask), 32'(TABLE[k].exp_mask));
      check($sformatf("R8 invalid entry %0d", k), 32'(out_invalid), 32'(TABLE[k].exp_inv));
    end

    // R9: idle cycles hold result with valid low, even with changed inputs
    vec_data = '0; scalar = '0; vl = 4'd8; ew_sel = 2'd0;
    @(negedge clk);
    check("R9 idle valid", 32'(out_valid), 32'd0);
    check("R9 hold mask", 32'(out_mask), 32'hF0);
    check("R9 hold invalid", 32'(out_invalid), 32'd0);

    // R4 R8: NaN active lane then back-to-back operation
    apply(TABLE[0]);
    @(negedge clk);
    check("R8 b2b first", 32'(out_invalid), 32'd1);
    apply(TABLE[1]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b valid", 32'(out_valid), 32'd1);
    check("R1 b2b mask", 32'(out_mask), 32'h56);
    check("R8 b2b second", 32'(out_invalid), 32'd0);

    // R10: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 re-reset mask", 32'(out_mask), 32'd0);
    check("R10 re-reset valid", 32'(out_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule